// File: doc/BRIEF.md
# Interrupt Aggregation and Dispatch Controller

This block collects interrupt flags from a set of peripheral modules. Each flag is masked by its own enable. For every module, the surviving flags are merged into one identification bit. The identification bits are captured on the rising clock edge into three read-only summary registers, which the CPU can read through a small combinational read port.

When any identification bit is set and the global interrupt enable is on, a five-state sequencer takes over. It always waits one stall cycle after detection, so the instruction in flight can finish its own stack access. If the CPU reports an exception window during that stall, the sequencer waits one more cycle. It then performs a call-like sequence in two cycles: one cycle pushes the return address, and the next cycle loads the program counter with the vector address.

The global enable is cleared automatically as the push is committed. A request that is still present therefore stays pending until software sets the enable again.

Top module: `irq_dispatch_ctrl`

## Requirements
- R1: After reset, every read select returns 0, `gie` is 0, and `stk_push`, `pc_load` and `int_ack` are all 0.
- R2: A module's identification bit is the OR over its sources of (flag AND enable). The bit is registered, so it appears on the read port in the cycle after the flags are applied. A flag whose enable is 0 has no effect.
- R3: `rd_sel`=0 selects summary register A. Bit 8 is the I2C-master summary, bit 7 is the supply-monitor bit, and bits 6..0 are external pins 6..0. Bits 15..9 read 0.
- R4: `rd_sel`=1 selects summary register B: bit 2 is SPI slave, bit 1 is the three-wire port and bit 0 is the ADC. `rd_sel`=2 selects summary register C: bit 1 is the fast comparator and bit 0 is SPI master. All other bits, and all bits for `rd_sel`=3, read 0.
- R5: With `gie`=1 and no exception window, `stk_push` rises in the second cycle after the identification bit first reads nonzero. That cycle is the third clock edge after the flag is applied.
- R6: If `exc_window` is 1 during the stall cycle, the push comes exactly one cycle later than in R5. The stall cycle is the cycle after the identification bit first reads nonzero.
- R7: `stk_push` and `int_ack` are high for exactly one cycle, with `stk_data` equal to `ret_addr`. In the next cycle only `pc_load` is high, for exactly one cycle, with `pc_value` equal to `vec_addr`. While these outputs are low, their data buses are 0.
- R8: With `gie`=0 no push happens. `gie` reads 0 during the push cycle. `gie_set` sets it, and `gie_clr` wins when both are high.
- R9: If every identification bit is 0 again before the push point, no push or load happens, and `gie` stays 1.
- R10: A request still pending when the sequence ends is not taken again while `gie`=0. After `gie_set`, it is taken with a push in the third cycle after `gie_set` is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| i2cm_flag | input | I2CM_SRC_N | I2C master interrupt flags |
| i2cm_en | input | I2CM_SRC_N | I2C master per-flag enables |
| svm_flag | input | SVM_SRC_N | Supply monitor flags |
| svm_en | input | SVM_SRC_N | Supply monitor enables |
| pin_flag | input | 7 | External pin interrupt flags |
| pin_en | input | 7 | External pin enables |
| spis_flag | input | SPIS_SRC_N | SPI slave flags |
| spis_en | input | SPIS_SRC_N | SPI slave enables |
| tw_flag | input | TW_SRC_N | Three-wire port flags |
| tw_en | input | TW_SRC_N | Three-wire port enables |
| adc_flag | input | ADC_SRC_N | ADC flags |
| adc_en | input | ADC_SRC_N | ADC enables |
| cmp_flag | input | CMP_SRC_N | Fast comparator flags |
| cmp_en | input | CMP_SRC_N | Fast comparator enables |
| spim_flag | input | SPIM_SRC_N | SPI master flags |
| spim_en | input | SPIM_SRC_N | SPI master enables |
| gie_set | input | 1 | Sets the global interrupt enable |
| gie_clr | input | 1 | Clears the global interrupt enable (has priority) |
| exc_window | input | 1 | Current instruction opens an exception window |
| ret_addr | input | PC_W | Return address to push |
| vec_addr | input | PC_W | Interrupt vector address |
| rd_sel | input | 2 | Summary register select |
| rd_data | output | 16 | Selected summary register value |
| stk_push | output | 1 | Stack push strobe |
| stk_data | output | PC_W | Address pushed onto the stack |
| pc_load | output | 1 | Program counter load strobe |
| pc_value | output | PC_W | Vector loaded into the program counter |
| int_ack | output | 1 | Interrupt taken acknowledge |
| gie | output | 1 | Global interrupt enable state |

## Verification
If the sequencer holds the wrong state, the push strobe shows up a cycle early or late against the fixed count from flag to push. It can also show up as a push that never arrives, or as a repeated push without a following load. In every case the error is visible within three or four cycles of the request. If the enable handling is wrong, a second dispatch appears while `gie` should still be 0, or a withdrawn request still produces a call. A wrong identification register shows on the very next read, because the read port is combinational.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int REG_W = 16;
    localparam int PIN_N = 7;
    localparam int SUMA_W = PIN_N + 2;
    localparam int SUMB_W = 3;
    localparam int SUMC_W = 2;

    localparam logic [1:0] SEL_SUMA = 2'd0;
    localparam logic [1:0] SEL_SUMB = 2'd1;
    localparam logic [1:0] SEL_SUMC = 2'd2;

    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_STALL,
        SEQ_WINWAIT,
        SEQ_PUSH,
        SEQ_VECTOR
    } seq_state_e;

    typedef struct packed {
        logic [SUMA_W-1:0] suma;
        logic [SUMB_W-1:0] sumb;
        logic [SUMC_W-1:0] sumc;
    } id_bits_t;
endpackage

// File: rtl/irq_gather.sv
module irq_gather #(
    parameter int SRC_N = 1
) (
    input  logic [SRC_N-1:0] flag,
    input  logic [SRC_N-1:0] en,
    output logic             hit
);
    always_comb begin
        hit = |(flag & en);
    end
endmodule

// File: rtl/irq_idreg.sv
module irq_idreg
    import irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  id_bits_t         id_in,
    input  logic [1:0]       rd_sel,
    output logic [REG_W-1:0] rd_data,
    output logic             any_pending
);
    typedef struct packed {
        id_bits_t id;
    } idreg_t;

    idreg_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        s_d.id = id_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        rd_data = '0;
        unique case (rd_sel)
            SEL_SUMA: rd_data[SUMA_W-1:0] = s_q.id.suma;
            SEL_SUMB: rd_data[SUMB_W-1:0] = s_q.id.sumb;
            SEL_SUMC: rd_data[SUMC_W-1:0] = s_q.id.sumc;
            default:  rd_data = '0;
        endcase
        any_pending = |s_q.id;
    end
endmodule

// File: rtl/irq_seq.sv
module irq_seq
    import irq_pkg::*;
#(
    parameter int PC_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pending,
    input  logic            exc_window,
    input  logic            gie_set,
    input  logic            gie_clr,
    input  logic [PC_W-1:0] ret_addr,
    input  logic [PC_W-1:0] vec_addr,
    output logic            stk_push,
    output logic [PC_W-1:0] stk_data,
    output logic            pc_load,
    output logic [PC_W-1:0] pc_value,
    output logic            int_ack,
    output logic            gie
);
    typedef struct packed {
        seq_state_e st;
        logic       gie;
    } seq_t;

    seq_t s_d, s_q;
    logic go_on;

    always_comb begin
        s_d   = s_q;
        go_on = pending && s_q.gie;
        if (gie_set) begin
            s_d.gie = 1'b1;
        end
        if (gie_clr) begin
            s_d.gie = 1'b0;
        end
        unique case (s_q.st)
            SEQ_IDLE: begin
                if (go_on) begin
                    s_d.st = SEQ_STALL;
                end
            end
            SEQ_STALL: begin
                if (!go_on) begin
                    s_d.st = SEQ_IDLE;
                end else if (exc_window) begin
                    s_d.st = SEQ_WINWAIT;
                end else begin
                    s_d.st  = SEQ_PUSH;
                    s_d.gie = 1'b0;
                end
            end
            SEQ_WINWAIT: begin
                if (!go_on) begin
                    s_d.st = SEQ_IDLE;
                end else begin
                    s_d.st  = SEQ_PUSH;
                    s_d.gie = 1'b0;
                end
            end
            SEQ_PUSH:   s_d.st = SEQ_VECTOR;
            SEQ_VECTOR: s_d.st = SEQ_IDLE;
            default:    s_d.st = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.st  <= SEQ_IDLE;
            s_q.gie <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        stk_push = (s_q.st == SEQ_PUSH);
        pc_load  = (s_q.st == SEQ_VECTOR);
        stk_data = stk_push ? ret_addr : '0;
        pc_value = pc_load ? vec_addr : '0;
        int_ack  = stk_push;
        gie      = s_q.gie;
    end
endmodule

// File: rtl/irq_dispatch_ctrl.sv
module irq_dispatch_ctrl
    import irq_pkg::*;
#(
    parameter int PC_W       = 16,
    parameter int I2CM_SRC_N = 4,
    parameter int SVM_SRC_N  = 1,
    parameter int SPIS_SRC_N = 2,
    parameter int TW_SRC_N   = 2,
    parameter int ADC_SRC_N  = 3,
    parameter int CMP_SRC_N  = 1,
    parameter int SPIM_SRC_N = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [I2CM_SRC_N-1:0] i2cm_flag,
    input  logic [I2CM_SRC_N-1:0] i2cm_en,
    input  logic [SVM_SRC_N-1:0]  svm_flag,
    input  logic [SVM_SRC_N-1:0]  svm_en,
    input  logic [PIN_N-1:0]      pin_flag,
    input  logic [PIN_N-1:0]      pin_en,
    input  logic [SPIS_SRC_N-1:0] spis_flag,
    input  logic [SPIS_SRC_N-1:0] spis_en,
    input  logic [TW_SRC_N-1:0]   tw_flag,
    input  logic [TW_SRC_N-1:0]   tw_en,
    input  logic [ADC_SRC_N-1:0]  adc_flag,
    input  logic [ADC_SRC_N-1:0]  adc_en,
    input  logic [CMP_SRC_N-1:0]  cmp_flag,
    input  logic [CMP_SRC_N-1:0]  cmp_en,
    input  logic [SPIM_SRC_N-1:0] spim_flag,
    input  logic [SPIM_SRC_N-1:0] spim_en,
    input  logic                  gie_set,
    input  logic                  gie_clr,
    input  logic                  exc_window,
    input  logic [PC_W-1:0]       ret_addr,
    input  logic [PC_W-1:0]       vec_addr,
    input  logic [1:0]            rd_sel,
    output logic [REG_W-1:0]      rd_data,
    output logic                  stk_push,
    output logic [PC_W-1:0]       stk_data,
    output logic                  pc_load,
    output logic [PC_W-1:0]       pc_value,
    output logic                  int_ack,
    output logic                  gie
);
    logic [PIN_N-1:0] pin_hit;
    logic i2cm_hit, svm_hit, spis_hit, tw_hit, adc_hit, cmp_hit, spim_hit;
    logic any_pending;
    id_bits_t id_now;

    for (genvar g = 0; g < PIN_N; g++) begin : g_pin
        irq_gather #(.SRC_N(1)) i_pin (
            .flag (pin_flag[g]),
            .en   (pin_en[g]),
            .hit  (pin_hit[g])
        );
    end

    irq_gather #(.SRC_N(I2CM_SRC_N)) i_i2cm (.flag(i2cm_flag), .en(i2cm_en), .hit(i2cm_hit));
    irq_gather #(.SRC_N(SVM_SRC_N))  i_svm  (.flag(svm_flag),  .en(svm_en),  .hit(svm_hit));
    irq_gather #(.SRC_N(SPIS_SRC_N)) i_spis (.flag(spis_flag), .en(spis_en), .hit(spis_hit));
    irq_gather #(.SRC_N(TW_SRC_N))   i_tw   (.flag(tw_flag),   .en(tw_en),   .hit(tw_hit));
    irq_gather #(.SRC_N(ADC_SRC_N))  i_adc  (.flag(adc_flag),  .en(adc_en),  .hit(adc_hit));
    irq_gather #(.SRC_N(CMP_SRC_N))  i_cmp  (.flag(cmp_flag),  .en(cmp_en),  .hit(cmp_hit));
    irq_gather #(.SRC_N(SPIM_SRC_N)) i_spim (.flag(spim_flag), .en(spim_en), .hit(spim_hit));

    always_comb begin
        id_now.suma = {i2cm_hit, svm_hit, pin_hit};
        id_now.sumb = {spis_hit, tw_hit, adc_hit};
        id_now.sumc = {cmp_hit, spim_hit};
    end

    irq_idreg i_idreg (
        .clk         (clk),
        .rst_n       (rst_n),
        .id_in       (id_now),
        .rd_sel      (rd_sel),
        .rd_data     (rd_data),
        .any_pending (any_pending)
    );

    irq_seq #(.PC_W(PC_W)) i_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .pending    (any_pending),
        .exc_window (exc_window),
        .gie_set    (gie_set),
        .gie_clr    (gie_clr),
        .ret_addr   (ret_addr),
        .vec_addr   (vec_addr),
        .stk_push   (stk_push),
        .stk_data   (stk_data),
        .pc_load    (pc_load),
        .pc_value   (pc_value),
        .int_ack    (int_ack),
        .gie        (gie)
    );
endmodule

// File: rtl/irq_dispatch_chk.sv
module irq_dispatch_chk
    import irq_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             stk_push,
    input logic             pc_load,
    input logic             int_ack,
    input logic             gie,
    input logic [1:0]       rd_sel,
    input logic [REG_W-1:0] rd_data
);
    AST_LOAD_FOLLOWS_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        stk_push |=> pc_load); // R7
    AST_LOAD_HAS_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |-> $past(stk_push)); // R7
    AST_PUSH_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        stk_push |=> !stk_push); // R7
    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(stk_push && pc_load)); // R7
    AST_ACK_PAIRS_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        int_ack |-> stk_push); // R7
    AST_GIE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        stk_push |-> !gie); // R8
    AST_PUSH_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
        stk_push |-> $past(gie)); // R8
    AST_SUMA_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel == SEL_SUMA) |-> (rd_data[REG_W-1:SUMA_W] == '0)); // R3
endmodule

bind irq_dispatch_ctrl irq_dispatch_chk i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .stk_push (stk_push),
    .pc_load  (pc_load),
    .int_ack  (int_ack),
    .gie      (gie),
    .rd_sel   (rd_sel),
    .rd_data  (rd_data)
);

// File: tb/test_irq_dispatch_ctrl.sv
module test_irq_dispatch_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  i2cm_flag = '0, i2cm_en = '0;
    logic [0:0]  svm_flag = '0, svm_en = '0;
    logic [6:0]  pin_flag = '0, pin_en = '0;
    logic [1:0]  spis_flag = '0, spis_en = '0;
    logic [1:0]  tw_flag = '0, tw_en = '0;
    logic [2:0]  adc_flag = '0, adc_en = '0;
    logic [0:0]  cmp_flag = '0, cmp_en = '0;
    logic [1:0]  spim_flag = '0, spim_en = '0;
    logic        gie_set = 1'b0, gie_clr = 1'b0, exc_window = 1'b0;
    logic [15:0] ret_addr = '0, vec_addr = '0;
    logic [1:0]  rd_sel = '0;
    logic [15:0] rd_data;
    logic        stk_push, pc_load, int_ack, gie;
    logic [15:0] stk_data, pc_value;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    irq_dispatch_ctrl i_irq_dispatch_ctrl (
        .clk(clk), .rst_n(rst_n),
        .i2cm_flag(i2cm_flag), .i2cm_en(i2cm_en),
        .svm_flag(svm_flag), .svm_en(svm_en),
        .pin_flag(pin_flag), .pin_en(pin_en),
        .spis_flag(spis_flag), .spis_en(spis_en),
        .tw_flag(tw_flag), .tw_en(tw_en),
        .adc_flag(adc_flag), .adc_en(adc_en),
        .cmp_flag(cmp_flag), .cmp_en(cmp_en),
        .spim_flag(spim_flag), .spim_en(spim_en),
        .gie_set(gie_set), .gie_clr(gie_clr), .exc_window(exc_window),
        .ret_addr(ret_addr), .vec_addr(vec_addr),
        .rd_sel(rd_sel), .rd_data(rd_data),
        .stk_push(stk_push), .stk_data(stk_data),
        .pc_load(pc_load), .pc_value(pc_value),
        .int_ack(int_ack), .gie(gie)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_rd(input logic [1:0] sel);
        logic [15:0] v;
        v = '0;
        case (sel)
            2'd0: v = {7'd0, |(i2cm_flag & i2cm_en), |(svm_flag & svm_en), pin_flag & pin_en};
            2'd1: v = {13'd0, |(spis_flag & spis_en), |(tw_flag & tw_en), |(adc_flag & adc_en)};
            2'd2: v = {14'd0, |(cmp_flag & cmp_en), |(spim_flag & spim_en)};
            default: v = '0;
        endcase
        return v;
    endfunction

    task automatic clear_src();
        i2cm_flag = '0; i2cm_en = '0; svm_flag = '0; svm_en = '0;
        pin_flag = '0; pin_en = '0; spis_flag = '0; spis_en = '0;
        tw_flag = '0; tw_en = '0; adc_flag = '0; adc_en = '0;
        cmp_flag = '0; cmp_en = '0; spim_flag = '0; spim_en = '0;
    endtask

    task automatic pulse_gie_set();
        gie_set = 1'b1;
        tick();
        gie_set = 1'b0;
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL R7 watchdog actual=hung expected=finished");
            finish_run();
        end
    end

    initial begin
        logic [15:0] e;
        void'($urandom(32'd4711));
        repeat (3) tick();
        // R1: reset state
        for (int s = 0; s < 4; s++) begin
            rd_sel = s[1:0];
            #1;
            chk("R1 read", {16'd0, rd_data}, 32'd0);
        end
        chk("R1 gie", {31'd0, gie}, 32'd0);
        chk("R1 push", {31'd0, stk_push}, 32'd0);
        chk("R1 load", {31'd0, pc_load}, 32'd0);
        chk("R1 ack", {31'd0, int_ack}, 32'd0);
        rst_n = 1'b1;
        tick();

        // R2 R3 R4: random flags and enables, gie stays 0 (R8)
        for (int i = 0; i < 80; i++) begin
            i2cm_flag = 4'($urandom); i2cm_en = 4'($urandom);
            svm_flag = 1'($urandom); svm_en = 1'($urandom);
            pin_flag = 7'($urandom); pin_en = 7'($urandom);
            spis_flag = 2'($urandom); spis_en = 2'($urandom);
            tw_flag = 2'($urandom); tw_en = 2'($urandom);
            adc_flag = 3'($urandom); adc_en = 3'($urandom);
            cmp_flag = 1'($urandom); cmp_en = 1'($urandom);
            spim_flag = 2'($urandom); spim_en = 2'($urandom);
            rd_sel = 2'($urandom);
            e = exp_rd(rd_sel);
            tick();
            if (rd_sel == 2'd0) chk("R3 summary A", {16'd0, rd_data}, {16'd0, e});
            else chk("R4 summary B/C/none", {16'd0, rd_data}, {16'd0, e});
            chk("R8 no push while gie=0", {31'd0, stk_push}, 32'd0);
        end

        // R2: masked flag ignored, enabled flag seen next cycle
        clear_src();
        rd_sel = 2'd0;
        i2cm_flag = 4'b0010; i2cm_en = 4'b0100;
        tick();
        chk("R2 masked i2cm", {16'd0, rd_data}, 32'd0);
        i2cm_en = 4'b0110;
        #1;
        chk("R2 registered not yet", {16'd0, rd_data}, 32'd0);
        tick();
        chk("R2 i2cm summary bit8", {16'd0, rd_data}, 32'h100);
        clear_src();
        rd_sel = 2'd1; adc_flag = 3'b100; adc_en = 3'b100;
        tick();
        chk("R4 adc bit0", {16'd0, rd_data}, 32'h1);
        rd_sel = 2'd2;
        #1;
        chk("R4 summary C clear", {16'd0, rd_data}, 32'h0);
        rd_sel = 2'd3;
        #1;
        chk("R4 sel3 zero", {16'd0, rd_data}, 32'h0);
        clear_src();
        tick();

        // R8: set/clr priority
        gie_set = 1'b1; gie_clr = 1'b1;
        tick();
        gie_set = 1'b0; gie_clr = 1'b0;
        chk("R8 clr wins", {31'd0, gie}, 32'd0);

        // R5 R7: plain dispatch
        pulse_gie_set();
        chk("R8 gie set", {31'd0, gie}, 32'd1);
        ret_addr = 16'h1234; vec_addr = 16'h0800; rd_sel = 2'd0;
        pin_flag[3] = 1'b1; pin_en[3] = 1'b1;
        tick();
        chk("R3 pin3 bit", {16'd0, rd_data}, 32'h8);
        chk("R5 no push at id", {31'd0, stk_push}, 32'd0);
        tick();
        chk("R5 no push in stall", {31'd0, stk_push}, 32'd0);
        tick();
        chk("R5 push", {31'd0, stk_push}, 32'd1);
        chk("R7 ack", {31'd0, int_ack}, 32'd1);
        chk("R7 push data", {16'd0, stk_data}, 32'h1234);
        chk("R8 gie cleared", {31'd0, gie}, 32'd0);
        chk("R7 no load with push", {31'd0, pc_load}, 32'd0);
        tick();
        chk("R7 load", {31'd0, pc_load}, 32'd1);
        chk("R7 vector", {16'd0, pc_value}, 32'h0800);
        chk("R7 push one cycle", {31'd0, stk_push}, 32'd0);
        tick();
        chk("R7 load one cycle", {31'd0, pc_load}, 32'd0);
        chk("R7 data quiet", {16'd0, pc_value}, 32'd0);

        // R10: still pending, gie=0, nothing taken
        for (int k = 0; k < 4; k++) begin
            tick();
            chk("R10 held", {31'd0, stk_push}, 32'd0);
        end
        ret_addr = 16'h2222;
        pulse_gie_set();
        tick();
        chk("R10 stall", {31'd0, stk_push}, 32'd0);
        tick();
        chk("R10 retaken push", {31'd0, stk_push}, 32'd1);
        chk("R10 data", {16'd0, stk_data}, 32'h2222);
        clear_src();
        tick();
        tick();

        // R6: exception window during stall
        pulse_gie_set();
        spim_flag = 2'b01; spim_en = 2'b01; vec_addr = 16'h0C40;
        tick();
        tick();
        exc_window = 1'b1;
        tick();
        exc_window = 1'b0;
        chk("R6 delayed", {31'd0, stk_push}, 32'd0);
        tick();
        chk("R6 push", {31'd0, stk_push}, 32'd1);
        tick();
        chk("R6 load", {16'd0, pc_value}, 32'h0C40);
        clear_src();
        tick();

        // R9: request withdrawn before push
        pulse_gie_set();
        cmp_flag = 1'b1; cmp_en = 1'b1;
        tick();
        clear_src();
        for (int k = 0; k < 5; k++) begin
            tick();
            chk("R9 no push", {31'd0, stk_push}, 32'd0);
            chk("R9 no load", {31'd0, pc_load}, 32'd0);
        end
        chk("R9 gie kept", {31'd0, gie}, 32'd1);

        // R2: enabled off with gie=1, no dispatch
        tw_flag = 2'b11; tw_en = 2'b00;
        for (int k = 0; k < 4; k++) begin
            tick();
            chk("R2 masked no push", {31'd0, stk_push}, 32'd0);
        end

        done = 1'b1;
        finish_run();
    end
endmodule